// File: doc/BRIEF.md
# Operand Width and Load Extension Unit

This block takes an operand that was fetched at a selectable operation width and turns it into a register update and a set of status-flag updates. It fits the value to a register whose width is fixed at build time (16, 32 or 64 bits). A two-bit fill field chooses one of four policies:

- **Keep:** only the low slice of the register changes.
- **Sign-fill:** the bits above the slice copy its sign bit.
- **Zero-fill:** the bits above the slice are set to zero.
- **Ones-fill:** the bits above the slice are set to one.

The block supports three operation classes: load/transfer, add-with-carry and compare.

The width field gives the size of the incoming slice. In keep mode it is also the width at which the arithmetic runs. With any fill other than keep, the arithmetic runs on the full register. Loads take their N and Z flags from the slice as it was read. Arithmetic takes its flags from whatever width it actually ran at. A no-flags input blocks all flag writes, except for compares. The combinational core can be followed by an output register that a parameter switches on or off.

Top module: `owx_unit`

## Requirements
- R1: `width_sel` picks the slice width: 0 → 8 bits, 1 → 16, 2 → 32, 3 → 64. Any width larger than REG_W is clipped to REG_W.
- R2: A load (`op_sel`=0) with fill 0 (keep) replaces the low slice of `reg_old` with the operand slice and leaves every bit above the slice unchanged.
- R3: A load with fill 1, 2 or 3 writes the operand slice and fills every bit above it with, respectively, the slice's top bit, zeros or ones.
- R4: A load reports N equal to the top bit of the slice and Z set when the slice is all zeros, whatever the fill. The write mask `flag_we` (bit 3 = N, 2 = Z, 1 = C, 0 = V) is 4'b1100.
- R5: An add (`op_sel`=1) with fill 0 adds the slice, the low slice of `reg_old` and `carry_in` at slice width. It writes only that slice back and keeps the upper bits. C is the carry out of the slice, V is signed overflow at slice width, and N and Z come from the slice result. The mask is 4'b1111.
- R6: An add with a non-zero fill adds the filled operand to the whole of `reg_old` at REG_W bits, and all four flags come from the full-width result.
- R7: A compare (`op_sel`=2) leaves the register value unchanged. It forms `reg_old` minus the operand at slice width for fill 0, or at full width otherwise. It sets C when no borrow occurs, writes N, Z and C, and never writes V (mask 4'b1110).
- R8: When `no_flags`=1, the mask is 0 for loads and adds, while the register result is unaffected; compares still write their flags.
- R9: With the output register enabled (default), results appear one clock after the inputs. A synchronous active-low reset clears every output to zero.
- R10: `op_sel`=3 is a no-operation: the register value is passed through unchanged and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 2 | Operation class: 0 load, 1 add, 2 compare, 3 none |
| width_sel | input | 2 | Slice width code |
| fill_sel | input | 2 | Fill policy: 0 keep, 1 sign, 2 zero, 3 ones |
| operand | input | REG_W | Raw value as read; bits above the slice are ignored |
| reg_old | input | REG_W | Current register value |
| carry_in | input | 1 | Carry input for add |
| no_flags | input | 1 | Suppress flag writes (not for compare) |
| reg_new | output | REG_W | New register value |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value |
| flag_v | output | 1 | Overflow flag value |
| flag_we | output | 4 | Per-flag write mask {N,Z,C,V} |

## Verification
The assertions check the combinational result in every cycle outside reset, and they assume that all inputs are known and steady around each rising edge. The bench meets this by changing inputs only just after a falling edge. The assertions also assume that the operand bits above the slice may hold anything. The stimulus therefore puts non-zero junk there in several loads, so that any leak of those bits into the result would show up. REG_W is taken to be 16, 32 or 64. The bench runs at the default of 32, so the 64-bit width code exercises the clipping rule.

// File: rtl/owx_pkg.sv
// Shared types and helpers for the operand width / extension unit.
// Assumes register widths of 16, 32 or 64 bits.
package owx_pkg;

    typedef enum logic [1:0] {
        OWX_LOAD = 2'b00,
        OWX_ADD  = 2'b01,
        OWX_CMP  = 2'b10,
        OWX_NONE = 2'b11
    } owx_op_e;

    typedef enum logic [1:0] {
        OWX_KEEP = 2'b00,
        OWX_SIGN = 2'b01,
        OWX_ZERO = 2'b10,
        OWX_ONES = 2'b11
    } owx_fill_e;

    // Number of adder lanes: four slice widths plus one full-width lane
    localparam int OWX_LANES = 5;

    // Width of adder lane k for a register of regw bits
    function automatic int lane_w(input int k, input int regw);
        int w;
        w = (k < 4) ? (8 << k) : regw;
        return (w > regw) ? regw : w;
    endfunction

endpackage

// File: rtl/owx_extend.sv
// Slice and fill stage: masks the operand to the selected slice width
// (clipped to REG_W) and produces the filled full-width value.
// Assumes REG_W >= 16.
module owx_extend
    import owx_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic [1:0]       width_sel,
    input  owx_fill_e        fill,
    input  logic [REG_W-1:0] operand,
    output logic [REG_W-1:0] wmask,
    output logic [REG_W-1:0] slice_val,
    output logic [REG_W-1:0] ext_val,
    output logic             slice_msb
);

    localparam int IDXW = $clog2(REG_W);

    int                width;
    logic [IDXW-1:0]   top_idx;

    // Decode the slice width and build the bit mask for it
    always_comb begin
        width = lane_w(int'(width_sel), REG_W);
        for (int i = 0; i < REG_W; i++) begin
            wmask[i] = (i < width);
        end
        top_idx = IDXW'(width - 1);
    end

    // Cut the slice and apply the chosen fill above it
    always_comb begin
        slice_val = operand & wmask;
        slice_msb = operand[top_idx];
        case (fill)
            OWX_SIGN: ext_val = slice_val | (slice_msb ? ~wmask : '0);
            OWX_ONES: ext_val = slice_val | ~wmask;
            default:  ext_val = slice_val;
        endcase
    end

endmodule

// File: rtl/owx_lane.sv
// One adder lane of width W: a + b + cin with carry, signed overflow and
// sign. The result is zero-padded to REG_W. Assumes W <= REG_W.
module owx_lane #(
    parameter int W     = 8,
    parameter int REG_W = 32
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic             cin,
    output logic [REG_W-1:0] res,
    output logic             cout,
    output logic             ovf,
    output logic             neg
);

    logic [W:0] sum;

    // Add at lane width and derive the lane status bits
    always_comb begin
        sum  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        res  = '0;
        res[W-1:0] = sum[W-1:0];
        cout = sum[W];
        neg  = sum[W-1];
        ovf  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/owx_unit.sv
// Operand width and load extension unit. It fits an operand read at a
// selectable width into a REG_W register, runs a load, add-with-carry or
// compare, and produces N/Z/C/V with a per-flag write mask. The core is
// combinational; REG_OUT=1 adds one output register stage.
// Assumes REG_W is 16, 32 or 64 and the inputs are steady at each rising edge.
module owx_unit
    import owx_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_sel,
    input  logic [1:0]       width_sel,
    input  logic [1:0]       fill_sel,
    input  logic [REG_W-1:0] operand,
    input  logic [REG_W-1:0] reg_old,
    input  logic             carry_in,
    input  logic             no_flags,
    output logic [REG_W-1:0] reg_new,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v,
    output logic [3:0]       flag_we
);

    owx_op_e          op;
    owx_fill_e        fill;
    logic [REG_W-1:0] wmask, slice_val, ext_val, b_val;
    logic             slice_msb, cin_eff;

    assign op   = owx_op_e'(op_sel);
    assign fill = owx_fill_e'(fill_sel);

    owx_extend #(.REG_W(REG_W)) u_ext (
        .width_sel (width_sel),
        .fill      (fill),
        .operand   (operand),
        .wmask     (wmask),
        .slice_val (slice_val),
        .ext_val   (ext_val),
        .slice_msb (slice_msb)
    );

    // Compare is add of the inverted operand with a forced carry of one
    always_comb begin
        b_val   = (op == OWX_CMP) ? ~ext_val : ext_val;
        cin_eff = (op == OWX_CMP) ? 1'b1 : carry_in;
    end

    logic [REG_W-1:0] lane_res [OWX_LANES];
    logic [OWX_LANES-1:0] lane_c, lane_v, lane_n;

    for (genvar k = 0; k < OWX_LANES; k++) begin : g_lane
        localparam int LW = lane_w(k, REG_W);
        owx_lane #(.W(LW), .REG_W(REG_W)) u_lane (
            .a    (reg_old[LW-1:0]),
            .b    (b_val[LW-1:0]),
            .cin  (cin_eff),
            .res  (lane_res[k]),
            .cout (lane_c[k]),
            .ovf  (lane_v[k]),
            .neg  (lane_n[k])
        );
    end

    logic [2:0]       sel;
    logic [REG_W-1:0] ar_res;
    logic             ar_c, ar_v, ar_n;

    // Pick the slice lane for keep mode, else the full-width lane
    always_comb begin
        sel    = (fill == OWX_KEEP) ? {1'b0, width_sel} : 3'd4;
        ar_res = lane_res[sel];
        ar_c   = lane_c[sel];
        ar_v   = lane_v[sel];
        ar_n   = lane_n[sel];
    end

    logic [REG_W-1:0] nxt_reg;
    logic             nxt_n, nxt_z, nxt_c, nxt_v;
    logic [3:0]       nxt_we;

    // Form the register result, flag values and the flag write mask
    always_comb begin
        nxt_reg = reg_old;
        nxt_n   = 1'b0;
        nxt_z   = 1'b0;
        nxt_c   = 1'b0;
        nxt_v   = 1'b0;
        nxt_we  = 4'b0000;
        case (op)
            OWX_LOAD: begin
                nxt_reg = (fill == OWX_KEEP) ? ((reg_old & ~wmask) | slice_val) : ext_val;
                nxt_n   = slice_msb;
                nxt_z   = (slice_val == '0);
                nxt_we  = 4'b1100;
            end
            OWX_ADD: begin
                nxt_reg = (fill == OWX_KEEP) ? ((reg_old & ~wmask) | ar_res) : ar_res;
                nxt_n   = ar_n;
                nxt_z   = (ar_res == '0);
                nxt_c   = ar_c;
                nxt_v   = ar_v;
                nxt_we  = 4'b1111;
            end
            OWX_CMP: begin
                nxt_n   = ar_n;
                nxt_z   = (ar_res == '0);
                nxt_c   = ar_c;
                nxt_we  = 4'b1110;
            end
            default: ;
        endcase
        if (no_flags && op != OWX_CMP) begin
            nxt_we = 4'b0000;
        end
    end

    if (REG_OUT) begin : g_reg
        // Output stage with synchronous active-low reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_new <= '0;
                flag_n  <= 1'b0;
                flag_z  <= 1'b0;
                flag_c  <= 1'b0;
                flag_v  <= 1'b0;
                flag_we <= 4'b0000;
            end else begin
                reg_new <= nxt_reg;
                flag_n  <= nxt_n;
                flag_z  <= nxt_z;
                flag_c  <= nxt_c;
                flag_v  <= nxt_v;
                flag_we <= nxt_we;
            end
        end

        // R9
        latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (reg_new == $past(nxt_reg) && flag_we == $past(nxt_we)));
    end else begin : g_comb
        // Combinational outputs
        always_comb begin
            reg_new = nxt_reg;
            flag_n  = nxt_n;
            flag_z  = nxt_z;
            flag_c  = nxt_c;
            flag_v  = nxt_v;
            flag_we = nxt_we;
        end
    end

    // R2
    keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OWX_LOAD && fill == OWX_KEEP) |-> (((nxt_reg ^ reg_old) & ~wmask) == '0));

    // R3
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OWX_LOAD && fill == OWX_ZERO) |-> ((nxt_reg & ~wmask) == '0));

    // R3
    ones_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OWX_LOAD && fill == OWX_ONES) |-> ((nxt_reg | wmask) == '1));

    // R7
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OWX_CMP) |-> (nxt_reg == reg_old && !nxt_we[0] && nxt_we[1]));

    // R8
    no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (no_flags && op != OWX_CMP) |-> (nxt_we == 4'b0000));

    // R10
    idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OWX_NONE) |-> (nxt_reg == reg_old && nxt_we == 4'b0000));

endmodule

// File: tb/sim_owx_unit.sv
// Directed bench for owx_unit at REG_W=32 with the output register on.
module sim_owx_unit;

    localparam int RW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    op_sel = 2'd3, width_sel = 2'd0, fill_sel = 2'd0;
    logic [RW-1:0] operand = '0, reg_old = '0;
    logic          carry_in = 1'b0, no_flags = 1'b0;
    logic [RW-1:0] reg_new;
    logic          flag_n, flag_z, flag_c, flag_v;
    logic [3:0]    flag_we;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    owx_unit #(.REG_W(RW), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .width_sel(width_sel),
        .fill_sel(fill_sel), .operand(operand), .reg_old(reg_old),
        .carry_in(carry_in), .no_flags(no_flags), .reg_new(reg_new),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .flag_we(flag_we)
    );

    // Drive one operation and wait until its registered result is visible
    task automatic run(input logic [1:0] op, input logic [1:0] ws, input logic [1:0] fs,
                       input logic [RW-1:0] opnd, input logic [RW-1:0] old,
                       input logic ci, input logic nf);
        @(negedge clk);
        op_sel = op; width_sel = ws; fill_sel = fs;
        operand = opnd; reg_old = old; carry_in = ci; no_flags = nf;
        @(negedge clk);
    endtask

    // Compare register, mask and the written flags ({N,Z,C,V}) with expectations
    task automatic expect_out(input string tag, input logic [RW-1:0] exp_reg,
                              input logic [3:0] exp_we, input logic [3:0] exp_f);
        logic [3:0] got_f;
        got_f = {flag_n, flag_z, flag_c, flag_v};
        checks++;
        if (reg_new !== exp_reg || flag_we !== exp_we || ((got_f ^ exp_f) & exp_we) != 4'b0) begin
            errors++;
            $display("FAIL %s: reg=%h we=%b f=%b expected reg=%h we=%b f=%b",
                     tag, reg_new, flag_we, got_f, exp_reg, exp_we, exp_f);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        expect_out("R9 reset clears outputs", '0, 4'b0000, 4'b0000);
    endtask

    task automatic t_load_keep;
        run(2'd0, 2'd0, 2'd0, 32'h5555_7792, 32'hAABB_CCDD, 1'b0, 1'b0);
        expect_out("R2 R4 keep load 8b", 32'hAABB_CC92, 4'b1100, 4'b1000);
        run(2'd0, 2'd3, 2'd0, 32'h8000_0001, 32'h1234_5678, 1'b0, 1'b0);
        expect_out("R1 64b code clipped to 32", 32'h8000_0001, 4'b1100, 4'b1000);
    endtask

    task automatic t_load_fill;
        run(2'd0, 2'd0, 2'd1, 32'h0000_0092, 32'h0, 1'b0, 1'b0);
        expect_out("R3 sign fill", 32'hFFFF_FF92, 4'b1100, 4'b1000);
        run(2'd0, 2'd1, 2'd2, 32'h1234_0000, 32'hFFFF_FFFF, 1'b0, 1'b0);
        expect_out("R3 R4 R1 zero fill 16b", 32'h0000_0000, 4'b1100, 4'b0100);
        run(2'd0, 2'd0, 2'd3, 32'h9900_0005, 32'h0, 1'b0, 1'b0);
        expect_out("R3 R4 ones fill, flags from slice", 32'hFFFF_FF05, 4'b1100, 4'b0000);
    endtask

    task automatic t_add_slice;
        run(2'd1, 2'd0, 2'd0, 32'h0000_0001, 32'h1234_56FF, 1'b0, 1'b0);
        expect_out("R5 8b carry out", 32'h1234_5600, 4'b1111, 4'b0110);
        run(2'd1, 2'd0, 2'd0, 32'h0000_0001, 32'h0000_007F, 1'b0, 1'b0);
        expect_out("R5 8b overflow", 32'h0000_0080, 4'b1111, 4'b1001);
        run(2'd1, 2'd1, 2'd0, 32'h0000_8000, 32'hABCD_8000, 1'b0, 1'b0);
        expect_out("R5 R1 16b carry and overflow", 32'hABCD_0000, 4'b1111, 4'b0111);
        run(2'd1, 2'd0, 2'd0, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0);
        expect_out("R5 carry_in used", 32'h0000_0002, 4'b1111, 4'b0000);
    endtask

    task automatic t_add_full;
        run(2'd1, 2'd0, 2'd1, 32'h0000_0092, 32'h0000_0010, 1'b0, 1'b0);
        expect_out("R6 sign-filled add", 32'hFFFF_FFA2, 4'b1111, 4'b1000);
        run(2'd1, 2'd1, 2'd2, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 1'b0);
        expect_out("R6 full-width carry", 32'h0000_0000, 4'b1111, 4'b0110);
    endtask

    task automatic t_compare;
        run(2'd2, 2'd0, 2'd0, 32'h0000_0050, 32'hAA00_0050, 1'b0, 1'b1);
        expect_out("R7 R8 equal, no_flags ignored", 32'hAA00_0050, 4'b1110, 4'b0110);
        run(2'd2, 2'd0, 2'd0, 32'h0000_0020, 32'h0000_0010, 1'b0, 1'b0);
        expect_out("R7 borrow", 32'h0000_0010, 4'b1110, 4'b1000);
        run(2'd2, 2'd0, 2'd2, 32'h0000_00FF, 32'h0000_0100, 1'b0, 1'b0);
        expect_out("R7 full width", 32'h0000_0100, 4'b1110, 4'b0010);
    endtask

    task automatic t_misc;
        run(2'd1, 2'd0, 2'd0, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b1);
        expect_out("R8 add with no_flags", 32'h0000_0002, 4'b0000, 4'b0000);
        run(2'd0, 2'd0, 2'd2, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1);
        expect_out("R8 load with no_flags", 32'h0000_0000, 4'b0000, 4'b0000);
        run(2'd3, 2'd2, 2'd1, 32'hFFFF_FFFF, 32'h1357_9BDF, 1'b1, 1'b0);
        expect_out("R10 no-op", 32'h1357_9BDF, 4'b0000, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_load_keep();
        t_load_fill();
        t_add_slice();
        t_add_full();
        t_compare();
        t_misc();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule